// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block is a management-bus master for external PHYs. Software programs it through four 32-bit registers on a simple synchronous register port, and the block serialises complete management frames on an MDC clock and a bidirectional MDIO data line. The data line is split into separate output, output-enable and input pins, and the pad sits outside the block. One register set serves both the short (Clause 22) and the extended (Clause 45) frame formats. A mode bit in the configuration register selects the format.

Three register writes launch frames. A write to the address register, with extended mode selected, sends an address frame. A write to the control register with its read bit set sends a read frame. A write to the data register sends a write frame. Busy is visible in both the configuration register and the data register, so software can poll either one before it programs the next transaction. During a read, the block releases MDIO for turnaround and data. If no PHY pulls the line low in the second turnaround bit, the block sets a read-error flag.

Register offsets on `reg_addr`: 0 = configuration/status, 1 = control, 2 = address, 3 = data.

Top module: `mdio_master`

## Requirements
- R1: After reset the configuration register reads `DIV_RST` in bits [31:16] and zero elsewhere: busy (bit 0), read error (bit 1), extended-mode (bit 2) and falling-edge-sample (bit 3) are all clear. MDC is low and `mdio_oe` is low.
- R2: MDC is held low while no frame is active. During a frame it toggles every (divider+1) system clocks, so one MDC period is 2*(divider+1) clocks.
- R3: A frame is 64 MDC bits, sent MSB first. The bits are 32 ones, a 2-bit start code, a 2-bit opcode, the 5-bit PHY address (control bits [9:5]), the 5-bit device/register field (control bits [4:0]), the 2-bit turnaround 10, and 16 data bits. In short mode a data-register write sends start 01 and opcode 01 with data bits [15:0].
- R4: A control write with bit 15 set sends a read frame (short mode: start 01, opcode 10). The block drives the first 46 bits and releases `mdio_oe` for the last 18. It captures the 16 bits after turnaround, MSB first, into data-register bits [15:0].
- R5: In extended mode an address-register write sends start 00, opcode 00 with the written bits [15:0] as data. In short mode the same write only stores the value and sends no frame.
- R6: In extended mode a read frame uses start 00, opcode 11, and a write frame uses start 00, opcode 01.
- R7: While a frame is active, configuration bit 0 and data-register bit 31 both read 1. Both return to 0 when the frame ends.
- R8: The read-error flag (configuration bit 1) is set when MDIO reads 1 in the second turnaround bit of a read. It is cleared when the next frame starts.
- R9: Writes to the control, address or data register while busy have no effect. They change no register and launch no frame.
- R10: With configuration bit 3 set, read bits are sampled on the MDC falling edge that ends each bit. With it clear, they are sampled on the rising edge in the middle of the bit.
- R11: A divider of 258 (configuration bits [31:16]) is supported and gives an MDC period of 518 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high = drive |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The embedded assertions check four things on every cycle: MDC stays low while idle, MDIO output holds steady between falling edges, an address write in short mode never raises busy, and the control fields stay frozen under writes made while busy. They also check that the error flag clears at the start of each frame. Only the bench scenarios can show the frame contents for each mode and opcode, the exact release window and the captured read word. They also show the different sampling point under the falling-edge option and the MDC period at both a small divider and 258, because each of these needs a responder and a whole frame.

// File: rtl/mdio_pkg.sv
// Shared constants, register offsets and frame builder for the MDIO master.
// Assumes 64-bit frames with a 32-bit preamble, MSB sent first.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = 6;
    localparam int TA_IDX     = 46;   // first turnaround bit
    localparam int TA_LOW_IDX = 47;   // bit a present PHY pulls low
    localparam int DATA_IDX   = 48;   // first data bit

    typedef enum logic [1:0] {
        OFS_CFG  = 2'd0,
        OFS_CTL  = 2'd1,
        OFS_ADDR = 2'd2,
        OFS_DATA = 2'd3
    } reg_ofs_e;

    // Assemble preamble, start, opcode, addresses, turnaround and payload.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic [1:0]  st,
        input logic [1:0]  op,
        input logic [4:0]  phy,
        input logic [4:0]  dev,
        input logic [15:0] payload
    );
        return {32'hFFFF_FFFF, st, op, phy, dev, 2'b10, payload};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: while run is high, MDC toggles every (div+1) clocks and
// one-cycle rise/fall strobes mark the edges. It assumes div is stable for
// the whole frame. MDC parks low while run is low.
module mdio_clkgen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick = run && (cnt == div);
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    // Count system clocks and flip MDC at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_serdes.sv
// Frame shifter: loads a 64-bit frame on start and drives bit 0 at once.
// It advances one bit per MDC falling edge. On read frames it releases
// MDIO from the turnaround onwards, checks the turnaround and shifts in
// 16 data bits at the selected sample edge. It assumes start only arrives
// while idle.
module mdio_serdes
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  is_rd,
    input  logic                  neg,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  mdio_i,
    output logic                  active,
    output logic                  rd_frame,
    output logic                  done,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  rd_err,
    output logic [15:0]           rdata
);
    logic [FRAME_BITS-1:0] sh;
    logic [IDX_W-1:0]      idx;
    logic                  sample;

    assign sample  = neg ? fall : rise;
    assign mdio_o  = sh[FRAME_BITS-1];
    assign mdio_oe = active && !(rd_frame && idx >= IDX_W'(TA_IDX));

    // Sequence the bits of one frame and flag its completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            rd_frame <= 1'b0;
            done     <= 1'b0;
            sh       <= '0;
            idx      <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active   <= 1'b1;
                rd_frame <= is_rd;
                sh       <= frame;
                idx      <= '0;
            end else if (active && fall) begin
                sh <= sh << 1;
                if (idx == IDX_W'(FRAME_BITS-1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // Capture turnaround status and read data at the chosen sample edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_err <= 1'b0;
            rdata  <= '0;
        end else if (start) begin
            rd_err <= 1'b0;
        end else if (active && rd_frame && sample) begin
            if (idx == IDX_W'(TA_LOW_IDX))
                rd_err <= mdio_i;
            if (idx >= IDX_W'(DATA_IDX))
                rdata <= {rdata[14:0], mdio_i};
        end
    end

    a_r8_err_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !rd_err);
    a_r3_hold_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fall && !start) |=> $stable(mdio_o));
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active);
endmodule

// File: rtl/mdio_master.sv
// Top level of the MDIO master: four software registers, launch decode for
// address, read and write frames, MDC generation and the frame shifter.
// It assumes single-cycle register writes and a combinational read mux.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 9,
    parameter int DIV_RST = 258
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int DIV_PAD = 16 - DIV_W;

    logic             ext_q, neg_q;
    logic [DIV_W-1:0] div_q;
    logic [4:0]       phy_q, dev_q;
    logic [15:0]      addr_q, data_q;

    logic             busy, rd_frame, done, rd_err;
    logic [15:0]      rdata;
    logic             rise, fall;
    logic             we_ok, launch, is_rd;
    logic [1:0]       st, op;
    logic [4:0]       l_phy, l_dev;
    logic [15:0]      payload;
    logic [FRAME_BITS-1:0] frame;

    assign we_ok = reg_we && !busy;
    assign st    = ext_q ? 2'b00 : 2'b01;

    // Decode which frame, if any, a register write launches.
    always_comb begin
        launch  = 1'b0;
        is_rd   = 1'b0;
        op      = 2'b01;
        l_phy   = phy_q;
        l_dev   = dev_q;
        payload = reg_wdata[15:0];
        if (we_ok) begin
            case (reg_ofs_e'(reg_addr))
                OFS_CTL: if (reg_wdata[15]) begin
                    launch = 1'b1;
                    is_rd  = 1'b1;
                    op     = ext_q ? 2'b11 : 2'b10;
                    l_phy  = reg_wdata[9:5];
                    l_dev  = reg_wdata[4:0];
                    payload = 16'hFFFF;
                end
                OFS_ADDR: if (ext_q) begin
                    launch = 1'b1;
                    op     = 2'b00;
                end
                OFS_DATA: launch = 1'b1;
                default: ;
            endcase
        end
    end

    assign frame = build_frame((launch && op == 2'b00) ? 2'b00 : st, op, l_phy, l_dev, payload);

    // Hold software-visible configuration, addressing and data values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q  <= 1'b0;
            neg_q  <= 1'b0;
            div_q  <= DIV_W'(DIV_RST);
            phy_q  <= '0;
            dev_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (reg_we && reg_ofs_e'(reg_addr) == OFS_CFG) begin
                ext_q <= reg_wdata[2];
                neg_q <= reg_wdata[3];
                div_q <= reg_wdata[16 +: DIV_W];
            end
            if (we_ok && reg_ofs_e'(reg_addr) == OFS_CTL) begin
                phy_q <= reg_wdata[9:5];
                dev_q <= reg_wdata[4:0];
            end
            if (we_ok && reg_ofs_e'(reg_addr) == OFS_ADDR)
                addr_q <= reg_wdata[15:0];
            if (we_ok && reg_ofs_e'(reg_addr) == OFS_DATA)
                data_q <= reg_wdata[15:0];
            else if (done && rd_frame)
                data_q <= rdata;
        end
    end

    // Present the addressed register to software.
    always_comb begin
        case (reg_ofs_e'(reg_addr))
            OFS_CFG:  reg_rdata = {{DIV_PAD{1'b0}}, div_q, 12'b0, neg_q, ext_q, rd_err, busy};
            OFS_CTL:  reg_rdata = {22'b0, phy_q, dev_q};
            OFS_ADDR: reg_rdata = {16'b0, addr_q};
            default:  reg_rdata = {busy, 15'b0, data_q};
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_serdes u_ser (
        .clk(clk), .rst_n(rst_n), .start(launch), .frame(frame), .is_rd(is_rd),
        .neg(neg_q), .rise(rise), .fall(fall), .mdio_i(mdio_i),
        .active(busy), .rd_frame(rd_frame), .done(done),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_err(rd_err), .rdata(rdata)
    );

    a_r9_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == 2'd1) |=> $stable({phy_q, dev_q}));
    a_r5_short_addr_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && reg_addr == 2'd2 && !ext_q) |=> !busy);
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // PHY responder state
    logic [63:0] cap = '0, oem = '0;
    int          bcnt = 0;
    bit          phy_on = 0, phy_late = 0;
    logic [15:0] phy_resp = '0;
    time         t_prev = 0, t_last = 0;

    localparam logic [63:0] RD_OE = 64'hFFFF_FFFF_FFFC_0000;

    always #5 clk = ~clk;

    mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    function automatic logic phy_val(input int i);
        if (phy_on && i == 47) return 1'b0;
        if (phy_on && i >= 48 && i <= 63) return phy_resp[63-i];
        return 1'b1;
    endfunction

    always @(posedge mdc) begin
        cap = {cap[62:0], mdio_oe ? mdio_o : mdio_i};
        oem = {oem[62:0], mdio_oe};
        bcnt++;
        t_prev = t_last;
        t_last = $time;
        if (phy_late) begin
            #1;
            mdio_i = phy_val(bcnt - 1);
        end
    end

    always @(negedge mdc) begin
        if (!phy_late) begin
            #1;
            mdio_i = phy_val(bcnt);
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int n = 0;
        do begin
            rd(2'd0, s);
            n++;
        end while (s[0] && n < 60000);
    endtask

    task automatic cfg(input int div, input bit ext, input bit neg);
        wr(2'd0, {16'(div), 12'b0, neg, ext, 2'b00});
    endtask

    task automatic arm(input bit on, input bit late, input logic [15:0] resp);
        phy_on = on; phy_late = late; phy_resp = resp;
        bcnt = 0; cap = '0; oem = '0; mdio_i = 1'b1;
    endtask

    function automatic logic [63:0] exp_frame(input logic [1:0] st, input logic [1:0] op,
        input logic [4:0] p, input logic [4:0] dv, input logic [15:0] d);
        return {32'hFFFF_FFFF, st, op, p, dv, 2'b10, d};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v);
        chk("R1 cfg reset", v, 32'h0102_0000);
        chk("R1 mdc low", mdc, 0);
        chk("R1 oe low", mdio_oe, 0);
    endtask

    task automatic t_short_write();
        logic [31:0] v;
        cfg(3, 0, 0);
        wr(2'd1, {22'b0, 5'h0A, 5'h11});
        arm(0, 0, 0);
        wr(2'd3, 32'h0000_A5C3);
        rd(2'd0, v); chk("R7 cfg busy", v[0], 1);
        rd(2'd3, v); chk("R7 data busy", v[31], 1);
        wait_idle();
        chk("R3 short write frame", cap, exp_frame(2'b01, 2'b01, 5'h0A, 5'h11, 16'hA5C3));
        chk("R3 bit count", bcnt, 64);
        chk("R3 oe whole frame", oem, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R2 mdc period div3", t_last - t_prev, 80);
        rd(2'd3, v); chk("R7 data busy clear", v[31], 0);
        repeat (20) @(negedge clk);
        chk("R2 mdc idle low", mdc, 0);
    endtask

    task automatic t_short_read();
        logic [31:0] v;
        arm(1, 0, 16'hBEEF);
        wr(2'd1, {16'b0, 1'b1, 5'b0, 5'h03, 5'h02});
        wait_idle();
        chk("R4 read drive part", cap & RD_OE, exp_frame(2'b01, 2'b10, 5'h03, 5'h02, 0) & RD_OE);
        chk("R4 release window", oem, RD_OE);
        rd(2'd3, v); chk("R4 read data", v[15:0], 16'hBEEF);
        rd(2'd0, v); chk("R8 no error when PHY answers", v[1], 0);
    endtask

    task automatic t_absent_read();
        logic [31:0] v;
        arm(0, 0, 0);
        wr(2'd1, {16'b0, 1'b1, 5'b0, 5'h1F, 5'h01});
        wait_idle();
        rd(2'd0, v); chk("R8 error on absent PHY", v[1], 1);
        arm(0, 0, 0);
        wr(2'd3, 32'h0000_0F0F);
        rd(2'd0, v); chk("R8 error cleared at next start", v[1], 0);
        wait_idle();
    endtask

    task automatic t_short_addr();
        logic [31:0] v;
        arm(0, 0, 0);
        wr(2'd2, 32'h0000_0BAD);
        repeat (40) @(negedge clk);
        rd(2'd0, v); chk("R5 no frame in short mode", v[0], 0);
        chk("R5 no mdc edges", bcnt, 0);
        rd(2'd2, v); chk("R5 address stored", v[15:0], 16'h0BAD);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(2'd1, {22'b0, 5'h03, 5'h04});
        arm(0, 0, 0);
        wr(2'd3, 32'h0000_1111);
        wr(2'd1, {16'b0, 1'b1, 5'b0, 5'h1F, 5'h1F});
        wr(2'd3, 32'h0000_2222);
        wr(2'd2, 32'h0000_3333);
        wait_idle();
        repeat (40) @(negedge clk);
        rd(2'd0, v); chk("R9 no second frame", v[0], 0);
        chk("R9 one frame only", bcnt, 64);
        chk("R9 frame unaffected", cap, exp_frame(2'b01, 2'b01, 5'h03, 5'h04, 16'h1111));
        rd(2'd1, v); chk("R9 control unchanged", v[9:0], {5'h03, 5'h04});
        rd(2'd3, v); chk("R9 data unchanged", v[15:0], 16'h1111);
        rd(2'd2, v); chk("R9 address unchanged", v[15:0], 16'h0BAD);
    endtask

    task automatic t_ext();
        logic [31:0] v;
        cfg(3, 1, 0);
        rd(2'd0, v); chk("R5 ext bit set", v[2], 1);
        wr(2'd1, {22'b0, 5'h07, 5'h1E});
        arm(0, 0, 0);
        wr(2'd2, 32'h0000_1234);
        rd(2'd0, v); chk("R5 ext address busy", v[0], 1);
        wait_idle();
        chk("R5 ext address frame", cap, exp_frame(2'b00, 2'b00, 5'h07, 5'h1E, 16'h1234));
        arm(1, 0, 16'h5A5A);
        wr(2'd1, {16'b0, 1'b1, 5'b0, 5'h07, 5'h1E});
        wait_idle();
        chk("R6 ext read frame", cap & RD_OE, exp_frame(2'b00, 2'b11, 5'h07, 5'h1E, 0) & RD_OE);
        rd(2'd3, v); chk("R6 ext read data", v[15:0], 16'h5A5A);
        arm(0, 0, 0);
        wr(2'd3, 32'h0000_C0DE);
        wait_idle();
        chk("R6 ext write frame", cap, exp_frame(2'b00, 2'b01, 5'h07, 5'h1E, 16'hC0DE));
    endtask

    task automatic t_neg_sample();
        logic [31:0] v;
        cfg(3, 0, 1);
        arm(1, 1, 16'h9C31);
        wr(2'd1, {16'b0, 1'b1, 5'b0, 5'h02, 5'h05});
        wait_idle();
        rd(2'd3, v); chk("R10 falling-edge read data", v[15:0], 16'h9C31);
        rd(2'd0, v); chk("R10 falling-edge turnaround ok", v[1], 0);
    endtask

    task automatic t_div258();
        logic [31:0] v;
        cfg(258, 0, 0);
        rd(2'd0, v); chk("R11 divider readback", v[31:16], 258);
        arm(0, 0, 0);
        wr(2'd3, 32'h0000_7E81);
        wait_idle();
        chk("R11 mdc period div258", t_last - t_prev, 5180);
        chk("R11 frame at div258", cap, exp_frame(2'b01, 2'b01, 5'h02, 5'h05, 16'h7E81));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_short_write();
        t_short_read();
        t_absent_read();
        t_short_addr();
        t_busy_ignore();
        t_ext();
        t_neg_sample();
        t_div258();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule